// File: doc/BRIEF.md
# Two-Slot Clock-Crossing FIFO

This block moves data or control words from one clock domain to an unrelated one. It holds them in two registers, and each side keeps a one-bit pointer. The producer offers a word on a valid/ready stream in the write clock domain. The consumer takes words from a valid/ready stream in the read clock domain.

Each pointer toggles once for every accepted transfer. It crosses to the opposite domain through a chain of synchronizer flops. The write side compares its own pointer with the synchronized copy of the read pointer to decide whether it is full. The read side compares its own pointer with the synchronized copy of the write pointer to decide whether it is empty.

Back-pressure rules:
- On the write side, a word moves only on a clock edge where `wr_valid` and `wr_ready` are both high. The producer keeps `wr_valid` and `wr_data` steady until that edge.
- On the read side, `rd_data` is meaningful while `rd_valid` is high. A word leaves only on an edge where `rd_valid` and `rd_ready` are both high.
- Once a word is in flight, the write side refuses the next one until the read pointer comes back across. At most one word is outstanding, and each transfer alternates between the two registers.

Top module: `cdc_pair_fifo`

## Requirements
- R1: After both domain resets, `wr_ready` is 1 and `rd_valid` is 0.
- R2: An accepted put (`wr_valid`=1 and `wr_ready`=1 at a `wr_clk` rising edge) stores `wr_data` in the register chosen by the write pointer and toggles that pointer. Successive words therefore alternate between the two registers and arrive with their values intact.
- R3: In the `wr_clk` cycle after an accepted put, `wr_ready` is 0. It stays 0 until the read side has removed that word.
- R4: After the `wr_clk` edge that accepts a put, `rd_valid` rises within three `rd_clk` cycles.
- R5: While `rd_valid` is 1 and no get happens, `rd_valid` stays 1 and `rd_data` holds the oldest unread word without change.
- R6: An accepted get (`rd_valid`=1 and `rd_ready`=1 at an `rd_clk` rising edge) removes the word. `rd_valid` is 0 in the next `rd_clk` cycle. `wr_ready` returns to 1 within three `wr_clk` cycles of that get.
- R7: A put offered while `wr_ready` is 0 is ignored. That word is never delivered, and no register or pointer changes. The next accepted word is delivered correctly.
- R8: A get offered while `rd_valid` is 0 is ignored. `rd_valid` stays 0, and a word written afterwards is delivered correctly.
- R9: With unrelated clock periods and irregular valid and ready patterns on both sides, every accepted word is delivered exactly once and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low |
| wr_valid | input | 1 | Producer offers a word |
| wr_data | input | DATA_W | Word offered by the producer |
| wr_ready | output | 1 | FIFO can take a word (not full) |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low |
| rd_valid | output | 1 | A word is available (not empty) |
| rd_data | output | DATA_W | Oldest unread word |
| rd_ready | input | 1 | Consumer takes the word |

## Verification
The most likely kind of bad internal state is a pointer that toggled wrongly or missed a toggle. Such a fault shows at the ports within about three cycles of the opposite clock:
- An extra toggle on the read side raises `rd_valid` with no write behind it.
- An extra toggle on the write side reopens `wr_ready` while a word is still unread.
- A missed toggle leaves the FIFO stuck full or stuck empty.

A register written at the wrong slot, or overwritten while full, shows up on the next transfer as a wrong `rd_data` value. The bench therefore gives every word a distinct value. It also times the flag edges against a window of three cycles of the opposite clock.

// File: rtl/cdc_pair_pkg.sv
package cdc_pair_pkg;
  // The storage is fixed at two registers; a one-bit pointer addresses them.
  localparam int unsigned SLOT_COUNT      = 2;
  localparam int unsigned MIN_SYNC_STAGES = 2;

  // Full/empty comparisons for single-bit pointers.
  function automatic logic ptrs_differ(input logic a, input logic b);
    return a ^ b;
  endfunction
endpackage

// File: rtl/cdc_pair_sync.sv
module cdc_pair_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int unsigned DEPTH = (STAGES < cdc_pair_pkg::MIN_SYNC_STAGES) ?
                                  cdc_pair_pkg::MIN_SYNC_STAGES : STAGES;

  logic [DEPTH-1:0] chain;

  // First stage samples the foreign-domain bit; later stages let it settle.
  genvar g;
  generate
    for (g = 0; g < DEPTH; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign q = chain[DEPTH-1];
endmodule

// File: rtl/cdc_pair_wr_side.sv
module cdc_pair_wr_side #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SLOTS = cdc_pair_pkg::SLOT_COUNT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [DATA_W-1:0]       in_data,
  input  logic                    peer_ptr_sync,
  output logic                    in_ready,
  output logic                    own_ptr,
  output logic [SLOTS*DATA_W-1:0] store
);
  logic full;
  logic accept;

  assign full     = cdc_pair_pkg::ptrs_differ(own_ptr, peer_ptr_sync);
  assign in_ready = !full;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      own_ptr <= 1'b0;
    else if (accept) own_ptr <= !own_ptr;
  end

  genvar s;
  generate
    for (s = 0; s < SLOTS; s++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          store[s*DATA_W +: DATA_W] <= '0;
        else if (accept && (own_ptr == s[0]))
          store[s*DATA_W +: DATA_W] <= in_data;
      end
    end
  endgenerate
endmodule

// File: rtl/cdc_pair_rd_side.sv
module cdc_pair_rd_side #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SLOTS = cdc_pair_pkg::SLOT_COUNT
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    out_ready,
  input  logic                    peer_ptr_sync,
  input  logic [SLOTS*DATA_W-1:0] store,
  output logic                    out_valid,
  output logic [DATA_W-1:0]       out_data,
  output logic                    own_ptr
);
  logic take;

  assign out_valid = cdc_pair_pkg::ptrs_differ(own_ptr, peer_ptr_sync);
  assign take      = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    own_ptr <= 1'b0;
    else if (take) own_ptr <= !own_ptr;
  end

  // The selected register is stable: the writer cannot touch it until this
  // pointer has moved and crossed back.
  always_comb begin
    out_data = store[DATA_W-1:0];
    for (int i = 0; i < SLOTS; i++)
      if (own_ptr == i[0]) out_data = store[i*DATA_W +: DATA_W];
  end
endmodule

// File: rtl/cdc_pair_fifo.sv
module cdc_pair_fifo #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              wr_rst_n,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_ready,
  input  logic              rd_clk,
  input  logic              rd_rst_n,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic              rd_ready
);
  localparam int unsigned SLOTS = cdc_pair_pkg::SLOT_COUNT;

  logic                    wr_ptr;
  logic                    rd_ptr;
  logic                    wr_ptr_in_rd;
  logic                    rd_ptr_in_wr;
  logic [SLOTS*DATA_W-1:0] storage;

  cdc_pair_wr_side #(.DATA_W(DATA_W)) u_wr (
    .clk           (wr_clk),
    .rst_n         (wr_rst_n),
    .in_valid      (wr_valid),
    .in_data       (wr_data),
    .peer_ptr_sync (rd_ptr_in_wr),
    .in_ready      (wr_ready),
    .own_ptr       (wr_ptr),
    .store         (storage)
  );

  cdc_pair_sync #(.STAGES(SYNC_STAGES)) u_rptr_to_wr (
    .clk   (wr_clk),
    .rst_n (wr_rst_n),
    .d     (rd_ptr),
    .q     (rd_ptr_in_wr)
  );

  cdc_pair_sync #(.STAGES(SYNC_STAGES)) u_wptr_to_rd (
    .clk   (rd_clk),
    .rst_n (rd_rst_n),
    .d     (wr_ptr),
    .q     (wr_ptr_in_rd)
  );

  cdc_pair_rd_side #(.DATA_W(DATA_W)) u_rd (
    .clk           (rd_clk),
    .rst_n         (rd_rst_n),
    .out_ready     (rd_ready),
    .peer_ptr_sync (wr_ptr_in_rd),
    .store         (storage),
    .out_valid     (rd_valid),
    .out_data      (rd_data),
    .own_ptr       (rd_ptr)
  );
endmodule

// File: rtl/cdc_pair_fifo_chk.sv
module cdc_pair_fifo_chk #(
  parameter int unsigned DATA_W = 8,
  localparam int unsigned SLOTS = cdc_pair_pkg::SLOT_COUNT
) (
  input logic                    wr_clk,
  input logic                    wr_rst_n,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic                    wr_ptr,
  input logic [SLOTS*DATA_W-1:0] storage,
  input logic                    rd_clk,
  input logic                    rd_rst_n,
  input logic                    rd_valid,
  input logic                    rd_ready,
  input logic [DATA_W-1:0]       rd_data
);
  AST_PUT_TOGGLES_PTR: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_valid && wr_ready) |=> (wr_ptr != $past(wr_ptr))); // R2
  AST_FULL_AFTER_PUT: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (wr_valid && wr_ready) |=> !wr_ready); // R3
  AST_BLOCKED_PUT_NO_WRITE: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    !wr_ready |=> ($stable(storage) && $stable(wr_ptr))); // R7
  AST_HELD_WORD_STABLE: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data))); // R5
  AST_EMPTY_AFTER_GET: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_valid && rd_ready) |=> !rd_valid); // R6
endmodule

bind cdc_pair_fifo cdc_pair_fifo_chk #(.DATA_W(DATA_W)) u_chk (
  .wr_clk   (wr_clk),
  .wr_rst_n (wr_rst_n),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_ptr   (wr_ptr),
  .storage  (storage),
  .rd_clk   (rd_clk),
  .rd_rst_n (rd_rst_n),
  .rd_valid (rd_valid),
  .rd_ready (rd_ready),
  .rd_data  (rd_data)
);

// File: tb/test_cdc_pair_fifo.sv
`timescale 1ns/1ps
module test_cdc_pair_fifo;
  localparam int DW = 8;

  logic          wr_clk = 0, rd_clk = 0;
  logic          wr_rst_n = 0, rd_rst_n = 0;
  logic          wr_valid = 0, rd_ready = 0;
  logic [DW-1:0] wr_data = '0;
  logic          wr_ready, rd_valid;
  logic [DW-1:0] rd_data;

  int tests = 0, fails = 0;

  always #2.5  wr_clk = ~wr_clk;   // 200 MHz
  always #3.65 rd_clk = ~rd_clk;   // unrelated read clock

  cdc_pair_fifo #(.DATA_W(DW), .SYNC_STAGES(2)) i_cdc_pair_fifo (
    .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_ready(rd_ready));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Offer one word and hold it until accepted; returns after the accepting edge.
  task automatic put_word(input logic [DW-1:0] d);
    @(negedge wr_clk);
    while (!wr_ready) @(negedge wr_clk);
    wr_valid = 1; wr_data = d;
    @(negedge wr_clk);
    wr_valid = 0;
  endtask

  // Wait for a word, count read cycles spent waiting, take it.
  task automatic get_word(output logic [DW-1:0] d, output int waited);
    waited = 0;
    @(negedge rd_clk);
    while (!rd_valid && waited < 50) begin waited++; @(negedge rd_clk); end
    d = rd_data;
    rd_ready = 1;
    @(negedge rd_clk);
    rd_ready = 0;
  endtask

  task automatic t_reset();
    wr_rst_n = 0; rd_rst_n = 0;
    repeat (4) @(negedge wr_clk);
    wr_rst_n = 1;
    @(negedge rd_clk); rd_rst_n = 1;
    @(negedge wr_clk);
    check(wr_ready == 1, "R1 wr_ready after reset", wr_ready, 1);
    @(negedge rd_clk);
    check(rd_valid == 0, "R1 rd_valid after reset", rd_valid, 0);
  endtask

  task automatic t_single(input logic [DW-1:0] v);
    logic [DW-1:0] got; int n;
    put_word(v);
    check(wr_ready == 0, "R3 full after put", wr_ready, 0);
    n = 0;
    while (!rd_valid && n < 10) begin @(negedge rd_clk); n++; end
    check(n <= 3, "R4 rd_valid latency (rd cycles)", n, 3);
    check(wr_ready == 0, "R3 still full while unread", wr_ready, 0);
    repeat (3) @(negedge rd_clk);
    check(rd_valid == 1 && rd_data == v, "R5 word held", rd_data, v);
    rd_ready = 1; @(negedge rd_clk); rd_ready = 0;
    check(rd_valid == 0, "R6 empty after get", rd_valid, 0);
    n = 0;
    while (!wr_ready && n < 10) begin @(negedge wr_clk); n++; end
    check(n <= 3, "R6 wr_ready return (wr cycles)", n, 3);
    got = v; // single-word path done
  endtask

  task automatic t_blocked_put();
    logic [DW-1:0] got; int w;
    put_word(8'hA1);
    wr_valid = 1; wr_data = 8'hB2;
    repeat (3) begin
      @(negedge wr_clk);
      check(wr_ready == 0, "R7 put blocked while full", wr_ready, 0);
    end
    wr_valid = 0;
    get_word(got, w);
    check(got == 8'hA1, "R7 first word intact", got, 8'hA1);
    repeat (10) @(negedge rd_clk);
    check(rd_valid == 0, "R7 ignored word never delivered", rd_valid, 0);
    put_word(8'hC3);
    get_word(got, w);
    check(got == 8'hC3, "R7 next word after ignored put", got, 8'hC3);
  endtask

  task automatic t_get_empty();
    logic [DW-1:0] got; int w;
    repeat (6) @(negedge rd_clk);
    rd_ready = 1;
    repeat (5) begin
      @(negedge rd_clk);
      check(rd_valid == 0, "R8 get on empty ignored", rd_valid, 0);
    end
    rd_ready = 0;
    repeat (4) @(negedge rd_clk);
    check(rd_valid == 0, "R8 still empty", rd_valid, 0);
    put_word(8'h5D);
    get_word(got, w);
    check(got == 8'h5D, "R8 word after ignored gets", got, 8'h5D);
  endtask

  task automatic t_alternate();
    logic [DW-1:0] got; int w;
    for (int i = 0; i < 6; i++) begin
      put_word(DW'(8'h10 + i * 17));
      get_word(got, w);
      check(got == DW'(8'h10 + i * 17), "R2 alternating slots", got, 8'h10 + i * 17);
    end
  endtask

  task automatic t_stream();
    localparam int N = 40;
    int rx = 0, errs = 0;
    fork
      begin : producer
        int tx = 0, k = 0;
        while (tx < N) begin
          @(negedge wr_clk);
          k++;
          if (!wr_valid) begin
            wr_valid = (k % 3) != 0;
            wr_data  = DW'(tx * 37 + 5);
          end
          if (wr_valid && wr_ready) begin
            @(negedge wr_clk);
            wr_valid = 0;
            tx++;
          end
        end
      end
      begin : consumer
        int k = 0;
        while (rx < N && k < 5000) begin
          @(negedge rd_clk);
          k++;
          rd_ready = (k % 4) != 1;
          if (rd_valid && rd_ready) begin
            if (rd_data != DW'(rx * 37 + 5)) begin
              errs++;
              check(0, "R9 stream order", rd_data, DW'(rx * 37 + 5));
            end
            rx++;
          end
        end
        @(negedge rd_clk);
        rd_ready = 0;
      end
    join
    check(rx == N, "R9 word count", rx, N);
    check(errs == 0, "R9 no mismatches", errs, 0);
    repeat (10) @(negedge rd_clk);
    check(rd_valid == 0, "R9 no duplicate after stream", rd_valid, 0);
  endtask

  initial begin
    #500us;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_single(8'h3C);
    t_single(8'hE7);
    t_blocked_put();
    t_get_empty();
    t_alternate();
    t_stream();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule